// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block keeps the reservations that load-exclusive operations leave behind and decides whether a later store-exclusive may go ahead. Each requester has a local reservation slot. A second, global set of slots holds one tag per requester for memory that more than one agent can reach. Addresses arrive as physical addresses, with the shareable attribute already resolved. The block never touches memory.

A caller issues one command per cycle on a single request port. The command is one of: mark (set a reservation), check (ask whether a store-exclusive passes), local clear, or write snoop (an ordinary store seen on the fabric). Each command carries an address, a requester number, a size and a shareable flag. A check is answered one cycle later with a pass bit and an alignment-fault bit. A passing check also uses up the requester's local reservation. Other commands produce no response.

Top module: `excl_monitor`

## Requirements
- R1: After reset no local or global tag is held, so every check fails until a mark has been made.
- R2: A mark (req_op=1) with req_shared=1 writes the requester's tag into both the global and the local slot. With req_shared=0 it writes only the local slot and leaves the global slot unchanged.
- R3: A check (req_op=2) whose address is not a multiple of 2**req_size bytes answers rsp_fault=1 and rsp_pass=0 and changes no tag.
- R4: An aligned check with req_shared=0 passes exactly when the requester's local tag is valid and equals the address and size.
- R5: An aligned check with req_shared=1 passes only when both the local and the global tag of that requester equal the address and size.
- R6: A passing check invalidates that requester's local tag, so an identical check that follows fails. The global tag is not affected.
- R7: A write snoop (req_op=4) with req_shared=1 invalidates every requester's global tag that lies in the same naturally aligned block as the write, where the block size is the larger of the two sizes. With req_shared=0 the snoop changes nothing.
- R8: A local clear (req_op=3) invalidates only the issuing requester's local tag.
- R9: A new mark by a requester replaces that requester's earlier tag. The size is part of the match, and req_size encodes 1, 2, 4 or 8 bytes as 0 to 3.
- R10: rsp_valid is high in exactly the cycle after a check (req_op=2 with req_valid). rsp_pass and rsp_fault are low whenever rsp_valid is low. req_op=0 is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Command present this cycle |
| req_op | input | 3 | 0 idle, 1 mark, 2 check, 3 local clear, 4 write snoop |
| req_addr | input | AW | Physical address |
| req_id | input | ID_W | Requester number |
| req_size | input | SW | Log2 of the access size in bytes |
| req_shared | input | 1 | Address is shareable |
| rsp_valid | output | 1 | Check response present |
| rsp_pass | output | 1 | Store-exclusive may complete |
| rsp_fault | output | 1 | Check address misaligned |

## Verification
The hardest case to reach is a requester whose global tag has been removed by another agent's write while its local tag is still valid. In that state a shareable check must fail, but a non-shareable check of the same triple still passes. The stimulus reaches it by marking the same block from two requesters and then snooping a narrower write inside that block. It then probes one requester with a shareable check and the other with a non-shareable check. A randomized phase follows, with a small pool of addresses, which makes marks, snoops and checks collide often. A behavioural model judges every cycle.

// File: rtl/excl_monitor.sv
module excl_monitor #(
  parameter int ID_W = 2,
  parameter int AW   = 32,
  parameter int SW   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [2:0]      req_op,
  input  logic [AW-1:0]   req_addr,
  input  logic [ID_W-1:0] req_id,
  input  logic [SW-1:0]   req_size,
  input  logic            req_shared,
  output logic            rsp_valid,
  output logic            rsp_pass,
  output logic            rsp_fault
);
  localparam int NREQ = 1 << ID_W;
  localparam logic [2:0] OP_MARK = 3'd1;
  localparam logic [2:0] OP_CHK  = 3'd2;
  localparam logic [2:0] OP_CLR  = 3'd3;
  localparam logic [2:0] OP_WR   = 3'd4;

  logic [NREQ-1:0] loc_v, glb_v;
  logic [AW-1:0]   loc_a [NREQ];
  logic [AW-1:0]   glb_a [NREQ];
  logic [SW-1:0]   loc_s [NREQ];
  logic [SW-1:0]   glb_s [NREQ];

  function automatic logic [AW-1:0] low_bits(input logic [SW-1:0] s);
    return (AW'(1) << s) - AW'(1);
  endfunction

  logic is_chk, misal, l_hit, g_hit, ok;
  logic [NREQ-1:0] snoop_hit;

  assign is_chk = req_valid && (req_op == OP_CHK);
  assign misal  = |(req_addr & low_bits(req_size));
  assign l_hit  = loc_v[req_id] && (loc_a[req_id] == req_addr) && (loc_s[req_id] == req_size);
  assign g_hit  = glb_v[req_id] && (glb_a[req_id] == req_addr) && (glb_s[req_id] == req_size);
  assign ok     = !misal && l_hit && (!req_shared || g_hit);

  for (genvar i = 0; i < NREQ; i++) begin : g_snoop
    logic [SW-1:0] big;
    assign big = (glb_s[i] > req_size) ? glb_s[i] : req_size;
    assign snoop_hit[i] = glb_v[i] && ((glb_a[i] & ~low_bits(big)) == (req_addr & ~low_bits(big)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loc_v     <= '0;
      glb_v     <= '0;
      rsp_valid <= 1'b0;
      rsp_pass  <= 1'b0;
      rsp_fault <= 1'b0;
      for (int i = 0; i < NREQ; i++) begin
        loc_a[i] <= '0;
        glb_a[i] <= '0;
        loc_s[i] <= '0;
        glb_s[i] <= '0;
      end
    end else begin
      rsp_valid <= is_chk;
      rsp_pass  <= is_chk && ok;
      rsp_fault <= is_chk && misal;
      if (req_valid) begin
        case (req_op)
          OP_MARK: begin
            loc_v[req_id] <= 1'b1;
            loc_a[req_id] <= req_addr;
            loc_s[req_id] <= req_size;
            if (req_shared) begin
              glb_v[req_id] <= 1'b1;
              glb_a[req_id] <= req_addr;
              glb_s[req_id] <= req_size;
            end
          end
          OP_CHK: if (ok) loc_v[req_id] <= 1'b0;
          OP_CLR: loc_v[req_id] <= 1'b0;
          OP_WR:  if (req_shared) glb_v <= glb_v & ~snoop_hit;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/excl_monitor_chk.sv
module excl_monitor_chk #(
  parameter int ID_W = 2,
  parameter int AW   = 32,
  parameter int SW   = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [2:0]      req_op,
  input logic [AW-1:0]   req_addr,
  input logic [ID_W-1:0] req_id,
  input logic [SW-1:0]   req_size,
  input logic            rsp_valid,
  input logic            rsp_pass,
  input logic            rsp_fault
);
  logic armed;
  always_ff @(posedge clk) armed <= rst_n;

  logic chk_now, bad_align;
  assign chk_now   = req_valid && (req_op == 3'd2);
  assign bad_align = |(req_addr & ((AW'(1) << req_size) - AW'(1)));

  p_fault_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_valid && !rsp_pass));

  p_misal_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_now && bad_align) |=> rsp_fault);

  p_resp_timing_r10: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (rsp_valid == $past(chk_now)));

  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_pass && !rsp_fault));

  p_clear_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && chk_now && $past(req_valid) && ($past(req_op) == 3'd3) && ($past(req_id) == req_id))
      |=> !rsp_pass);

  p_pass_consumes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && chk_now && rsp_pass && ($past(req_id) == req_id)) |=> !rsp_pass);
endmodule

bind excl_monitor excl_monitor_chk #(.ID_W(ID_W), .AW(AW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .req_addr(req_addr), .req_id(req_id), .req_size(req_size),
  .rsp_valid(rsp_valid), .rsp_pass(rsp_pass), .rsp_fault(rsp_fault)
);

// File: tb/excl_monitor_test.sv
`timescale 1ns/1ps
module excl_monitor_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_op = 3'd0;
  logic [31:0] req_addr = '0;
  logic [1:0] req_id = '0;
  logic [1:0] req_size = '0;
  logic req_shared = 1'b0;
  logic rsp_valid, rsp_pass, rsp_fault;

  always #4 clk = ~clk;

  excl_monitor uut (.*);

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  bit lv [4], gv [4];
  logic [31:0] la [4], ga [4];
  int ls [4], gs [4];
  bit ev, ep, ef;

  task automatic model(input int op, input logic [31:0] a, input int id, input int sz, input bit sh);
    ev = 0; ep = 0; ef = 0;
    case (op)
      1: begin
        lv[id] = 1; la[id] = a; ls[id] = sz;
        if (sh) begin gv[id] = 1; ga[id] = a; gs[id] = sz; end
      end
      2: begin
        ev = 1;
        if ((a % (32'd1 << sz)) != 0) ef = 1;
        else begin
          ep = lv[id] && la[id] == a && ls[id] == sz;
          if (sh) ep = ep && gv[id] && ga[id] == a && gs[id] == sz;
          if (ep) lv[id] = 0;
        end
      end
      3: lv[id] = 0;
      4: if (sh) for (int i = 0; i < 4; i++) begin
           int g;
           g = (gs[i] > sz) ? gs[i] : sz;
           if (gv[i] && (ga[i] / (32'd1 << g)) == (a / (32'd1 << g))) gv[i] = 0;
         end
      default: ;
    endcase
  endtask

  task automatic step(input int op, input logic [31:0] a, input int id, input int sz,
                      input bit sh, input string tag);
    @(negedge clk);
    req_valid = (op != 0); req_op = 3'(op); req_addr = a;
    req_id = 2'(id); req_size = 2'(sz); req_shared = sh;
    model(op, a, id, sz, sh);
    @(posedge clk); #1;
    checks++;
    if (rsp_valid !== ev || rsp_pass !== ep || rsp_fault !== ef) begin
      errors++;
      $display("FAIL %s: got valid=%b pass=%b fault=%b, expected valid=%b pass=%b fault=%b",
               tag, rsp_valid, rsp_pass, rsp_fault, ev, ep, ef);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 4; i++) begin lv[i] = 0; gv[i] = 0; la[i] = 0; ga[i] = 0; ls[i] = 0; gs[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state, R10 idle
    step(0, 0, 0, 0, 0, "R10 idle after reset");
    step(2, 32'h100, 0, 2, 1, "R1 check with no tags");
    step(2, 32'h100, 0, 2, 0, "R1 non-shared check with no tags");
    // R2 R5 R6
    step(1, 32'h100, 0, 2, 1, "R2 shared mark");
    step(2, 32'h100, 0, 2, 1, "R5 shared check passes");
    step(2, 32'h100, 0, 2, 1, "R6 repeat check fails");
    // R4, R2 non-shared leaves global empty
    step(1, 32'h200, 1, 2, 0, "R2 non-shared mark");
    step(2, 32'h200, 1, 2, 0, "R4 local-only check passes");
    step(1, 32'h200, 1, 2, 0, "R2 non-shared mark again");
    step(2, 32'h200, 1, 2, 1, "R5 shared check without global tag");
    // R3
    step(1, 32'h102, 2, 1, 0, "R3 mark");
    step(2, 32'h101, 2, 1, 0, "R3 misaligned check");
    step(2, 32'h102, 2, 2, 0, "R3 misaligned size 4");
    step(2, 32'h102, 2, 1, 0, "R3 tag untouched by fault");
    // R7 snoop clears global of both, local stays
    step(1, 32'h300, 0, 2, 1, "R7 mark id0");
    step(1, 32'h300, 1, 2, 1, "R7 mark id1");
    step(4, 32'h302, 3, 1, 1, "R7 shared write snoop");
    step(2, 32'h300, 0, 2, 1, "R7 shared check after snoop");
    step(2, 32'h300, 1, 2, 0, "R7 local survives snoop");
    step(1, 32'h400, 2, 2, 1, "R7 mark id2");
    step(4, 32'h400, 0, 2, 0, "R7 non-shared write");
    step(4, 32'h404, 0, 2, 1, "R7 shared write other block");
    step(2, 32'h400, 2, 2, 1, "R7 tag kept");
    // R8
    step(1, 32'h500, 0, 0, 0, "R8 mark id0");
    step(1, 32'h500, 3, 0, 0, "R8 mark id3");
    step(3, 32'h0, 0, 0, 0, "R8 clear id0");
    step(2, 32'h500, 0, 0, 0, "R8 cleared requester fails");
    step(2, 32'h500, 3, 0, 0, "R8 other requester passes");
    // R9
    step(1, 32'h600, 1, 2, 1, "R9 first mark");
    step(1, 32'h700, 1, 2, 1, "R9 replacing mark");
    step(2, 32'h600, 1, 2, 1, "R9 old tag gone");
    step(2, 32'h700, 1, 2, 1, "R9 new tag passes");
    step(1, 32'h800, 3, 3, 0, "R9 mark size 8");
    step(2, 32'h800, 3, 2, 0, "R9 size mismatch fails");
    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] pool [4];
      pool[0] = 32'h1000; pool[1] = 32'h1004; pool[2] = 32'h1008; pool[3] = 32'h1002;
      step(int'($urandom_range(0, 4)), pool[$urandom_range(0, 3)], int'($urandom_range(0, 3)),
           int'($urandom_range(0, 3)), bit'($urandom_range(0, 1)), "R4 R5 R7 R10 random");
    end
    step(0, 0, 0, 0, 0, "R10 final idle");
    finish_run();
  end
endmodule